// File: doc/BRIEF.md
# HDLC Channel Interrupt Status Unit

This block gathers interrupt events from two HDLC channels into one byte-wide status register that a host reads over a simple register bus. Each channel has a transmit FIFO and a receive FIFO. The block watches each FIFO's level and the transmitter's frame-control inputs, and from them detects three events per channel:

- **Pool ready**: the transmit FIFO can take another 32-byte block.
- **Pool full**: 32 bytes of an unfinished frame have reached the receive FIFO.
- **Underrun**: the transmit FIFO ran dry in the middle of a frame before any end-of-message was given.

Reading the status register returns its contents and clears them in the same access. A mask register stops chosen events from reaching the interrupt line. A visibility control decides whether masked events are still recorded in the status register.

An underrun locks the channel's transmitter. The block tells the transmitter to close the frame with an abort, then holds the transmitter and its FIFO in reset until the host reads the status register. The lockout is run by a per-channel state machine:

- States: `TX_RUN`, `TX_ABORT`, `TX_HELD`.
- Transitions:
  - run→abort on underrun.
  - abort→run if a status read happens in the same cycle, otherwise abort→held.
  - held→run on a status read.

Pool-full detection is run by a second per-channel state machine:

- States: `RX_BELOW`, `RX_ABOVE`.
- Transitions:
  - below→above when the frame count reaches 32 and the frame is not ending in that cycle.
  - above→below when the count falls under 32.

Top module: `hdlc_irq_unit`

## Requirements
- R1: Register map on `reg_addr`:
  - Address 0 is the status register. It is read-only, and writes to it are ignored. Channel c uses bit 3c for pool ready, bit 3c+1 for pool full and bit 3c+2 for underrun. Bits 7:6 always read zero.
  - Address 1 is the mask register. It is read/write, and a 1 masks the bit.
  - Address 2 is the control register. Bit 0 is the visibility control, and its other bits read zero.
  - `reg_rdata` shows the addressed register in the same cycle that `reg_rd` is high, and is 0 otherwise.
  - All registers reset to 0.
- R2: A status read returns the current contents and clears every status bit at the clock edge that ends the read. Reading the other addresses does not clear status.
- R3: An event detected in the same cycle as a status read is set in the status register after that read's clear.
- R4: When visibility is 0, a masked event is not recorded. When visibility is 1, a masked event is recorded in the status register.
- R5: `irq` is registered and is the OR of all status bits whose mask bit is 0. A masked bit never raises `irq`. `irq_summary` follows `irq`.
- R6: Pool full is flagged once when `rx_count` rises to 32 or more, unless `rx_frame_end` is high in that cycle. It fires again only after the count has dropped below 32.
- R7: Pool ready is flagged once when `tx_space` rises to 32 or more while the channel is in `TX_RUN`. It is also flagged on the first `TX_RUN` cycle after reset or release from lockout if `tx_space` is already 32 or more.
- R8: An underrun is detected when, in `TX_RUN`, `tx_busy` is high, `tx_space` equals the FIFO depth of 64 (FIFO empty) and `tx_eom` is low. It sets the underrun bit, and `tx_abort` is high for exactly the following cycle.
- R9: After an underrun, `tx_hold` stays high until a status read. While the channel is locked out, neither pool ready nor underrun is detected.
- R10: While `tx_eom` is high, an empty FIFO during a frame does not cause an underrun.
- R11: The two channels' events, lockouts and status bits are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while `reg_rd` is high |
| tx_space | input | 2×7 | Free bytes in each transmit FIFO (0..64) |
| tx_busy | input | 2 | Transmitter is inside a frame, per channel |
| tx_eom | input | 2 | End-of-message has been given for the current frame, per channel |
| rx_count | input | 2×7 | Bytes of the current frame held in each receive FIFO |
| rx_frame_end | input | 2 | Receive frame completes this cycle, per channel |
| tx_abort | output | 2 | Transmitter must end the frame with an abort, per channel |
| tx_hold | output | 2 | Transmitter and its FIFO held in reset, per channel |
| irq | output | 1 | Interrupt output, active high |
| irq_summary | output | 1 | One-bit summary for the global interrupt status |

## Verification
The bench sweeps every event of both channels through every combination of mask bit and visibility. Each case checks two things: that the bit is recorded or dropped exactly as R4 requires, and that `irq` stays low for masked events. A design that records hidden events, or that lets masked bits reach the interrupt line, fails these checks.

It also targets several ordering cases:
- An event that coincides with a status read; a design that clears last loses the event.
- A level that stays at or above 32; a level-triggered design keeps re-flagging.
- A frame that ends as it crosses 32.
- An underrun while end-of-message is pending.

For the lockout, it checks that a mask-register read does not release it, that a status read does, and that pool ready is flagged again after release. A design that releases on any read, or never rearms, fails these checks.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;

    typedef enum logic [1:0] {
        TX_RUN   = 2'd0,
        TX_ABORT = 2'd1,
        TX_HELD  = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_BELOW = 1'b0,
        RX_ABOVE = 1'b1
    } rx_state_e;

    localparam int unsigned STAT_W      = 8;
    localparam int unsigned BITS_PER_CH = 3;
    localparam int unsigned OFS_TXRDY   = 0;
    localparam int unsigned OFS_RXFULL  = 1;
    localparam int unsigned OFS_TXUND   = 2;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

endpackage

// File: rtl/hdlc_tx_guard.sv
module hdlc_tx_guard
    import hdlc_irq_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned THRESH = 32,
    parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_space,
    input  logic             tx_busy,
    input  logic             tx_eom,
    input  logic             stat_read,
    output logic             ev_ready,
    output logic             ev_underrun,
    output logic             tx_abort,
    output logic             tx_hold
);

    localparam logic [LVL_W-1:0] FULL_SPACE = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] BLOCK_LVL  = LVL_W'(THRESH);

    tx_state_e state_q, state_d;
    logic      room_now;
    logic      room_prev_q;
    logic      dry_frame;

    assign room_now  = (tx_space >= BLOCK_LVL);
    assign dry_frame = tx_busy && (tx_space == FULL_SPACE) && !tx_eom;

    assign ev_ready    = (state_q == TX_RUN) && room_now && !room_prev_q;
    assign ev_underrun = (state_q == TX_RUN) && dry_frame;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_RUN:   if (dry_frame) state_d = TX_ABORT;
            TX_ABORT: state_d = stat_read ? TX_RUN : TX_HELD;
            TX_HELD:  if (stat_read) state_d = TX_RUN;
            default:  state_d = TX_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= TX_RUN;
            room_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            room_prev_q <= room_now && (state_q == TX_RUN);
        end
    end

    always_comb begin
        tx_abort = 1'b0;
        tx_hold  = 1'b0;
        unique case (state_q)
            TX_RUN:   ;
            TX_ABORT: begin tx_abort = 1'b1; tx_hold = 1'b1; end
            TX_HELD:  tx_hold = 1'b1;
            default:  ;
        endcase
    end

    assert_abort_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort);

    assert_hold_until_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hold && !tx_abort && !stat_read) |=> tx_hold);

    assert_quiet_when_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hold |-> (!ev_ready && !ev_underrun));

endmodule

// File: rtl/hdlc_rx_watch.sv
module hdlc_rx_watch
    import hdlc_irq_pkg::*;
#(
    parameter int unsigned THRESH = 32,
    parameter int unsigned LVL_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_count,
    input  logic             rx_frame_end,
    output logic             ev_full
);

    localparam logic [LVL_W-1:0] BLOCK_LVL = LVL_W'(THRESH);

    rx_state_e state_q, state_d;
    logic      past_lvl;

    assign past_lvl = (rx_count >= BLOCK_LVL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_BELOW: if (past_lvl && !rx_frame_end) state_d = RX_ABOVE;
            RX_ABOVE: if (!past_lvl) state_d = RX_BELOW;
            default:  state_d = RX_BELOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_BELOW;
        else        state_q <= state_d;
    end

    always_comb begin
        ev_full = 1'b0;
        unique case (state_q)
            RX_BELOW: ev_full = past_lvl && !rx_frame_end;
            RX_ABOVE: ev_full = 1'b0;
            default:  ev_full = 1'b0;
        endcase
    end

    assert_full_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_full |=> !ev_full);

endmodule

// File: rtl/hdlc_irq_regs.sv
module hdlc_irq_regs
    import hdlc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [STAT_W-1:0] ev_vec,
    output logic              stat_read,
    output logic              irq,
    output logic              irq_summary
);

    logic [STAT_W-1:0] status_q, mask_q, set_v, stat_nxt;
    logic              vis_q;
    logic              irq_q;

    assign stat_read = reg_rd && (reg_addr == ADDR_STAT);
    assign set_v     = ev_vec & (~mask_q | {STAT_W{vis_q}});
    assign stat_nxt  = (stat_read ? '0 : status_q) | set_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
            vis_q    <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= stat_nxt;
            irq_q    <= |(stat_nxt & ~mask_q);
            if (reg_wr && reg_addr == ADDR_MASK) mask_q <= reg_wdata;
            if (reg_wr && reg_addr == ADDR_CTRL) vis_q  <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                ADDR_STAT: reg_rdata = status_q;
                ADDR_MASK: reg_rdata = mask_q;
                ADDR_CTRL: reg_rdata = {7'd0, vis_q};
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign irq         = irq_q;
    assign irq_summary = irq_q;

    assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_read && ev_vec == '0) |=> (status_q == '0));

    assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_read && set_v != '0) |=> ((status_q & $past(set_v)) == $past(set_v)));

    assert_hidden_not_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_read && !vis_q && !reg_wr) |=> ((status_q & $past(mask_q)) == '0));

    assert_irq_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (status_q != '0));

    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[STAT_W-1:STAT_W-2] == 2'b00);

endmodule

// File: rtl/hdlc_irq_unit.sv
module hdlc_irq_unit
    import hdlc_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned THRESH = 32,
    parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   reg_addr,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [7:0]                   reg_wdata,
    output logic [7:0]                   reg_rdata,
    input  logic [NUM_CH-1:0][LVL_W-1:0] tx_space,
    input  logic [NUM_CH-1:0]            tx_busy,
    input  logic [NUM_CH-1:0]            tx_eom,
    input  logic [NUM_CH-1:0][LVL_W-1:0] rx_count,
    input  logic [NUM_CH-1:0]            rx_frame_end,
    output logic [NUM_CH-1:0]            tx_abort,
    output logic [NUM_CH-1:0]            tx_hold,
    output logic                         irq,
    output logic                         irq_summary
);

    localparam int unsigned USED_BITS = NUM_CH * BITS_PER_CH;

    logic [NUM_CH-1:0] ev_rdy, ev_und, ev_full;
    logic [STAT_W-1:0] ev_vec;
    logic              stat_read;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        hdlc_tx_guard #(
            .DEPTH (DEPTH),
            .THRESH(THRESH),
            .LVL_W (LVL_W)
        ) u_tx (
            .clk        (clk),
            .rst_n      (rst_n),
            .tx_space   (tx_space[c]),
            .tx_busy    (tx_busy[c]),
            .tx_eom     (tx_eom[c]),
            .stat_read  (stat_read),
            .ev_ready   (ev_rdy[c]),
            .ev_underrun(ev_und[c]),
            .tx_abort   (tx_abort[c]),
            .tx_hold    (tx_hold[c])
        );

        hdlc_rx_watch #(
            .THRESH(THRESH),
            .LVL_W (LVL_W)
        ) u_rx (
            .clk         (clk),
            .rst_n       (rst_n),
            .rx_count    (rx_count[c]),
            .rx_frame_end(rx_frame_end[c]),
            .ev_full     (ev_full[c])
        );
    end

    always_comb begin
        ev_vec = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            ev_vec[c*BITS_PER_CH + OFS_TXRDY]  = ev_rdy[c];
            ev_vec[c*BITS_PER_CH + OFS_RXFULL] = ev_full[c];
            ev_vec[c*BITS_PER_CH + OFS_TXUND]  = ev_und[c];
        end
    end

    hdlc_irq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ev_vec     (ev_vec),
        .stat_read  (stat_read),
        .irq        (irq),
        .irq_summary(irq_summary)
    );

    initial begin
        if (USED_BITS > STAT_W - 2) $error("channel count exceeds status width");
    end

endmodule

// File: tb/hdlc_irq_unit_bench.sv
`timescale 1ns/1ps
module hdlc_irq_unit_bench;

    localparam int NCH = 2;
    localparam int LW  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic [NCH-1:0][LW-1:0] tx_space;
    logic [NCH-1:0]    tx_busy = '0;
    logic [NCH-1:0]    tx_eom = '0;
    logic [NCH-1:0][LW-1:0] rx_count;
    logic [NCH-1:0]    rx_frame_end = '0;
    logic [NCH-1:0]    tx_abort, tx_hold;
    logic              irq, irq_summary;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hdlc_irq_unit u_hdlc_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_space(tx_space), .tx_busy(tx_busy), .tx_eom(tx_eom),
        .rx_count(rx_count), .rx_frame_end(rx_frame_end),
        .tx_abort(tx_abort), .tx_hold(tx_hold),
        .irq(irq), .irq_summary(irq_summary)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flush();
        logic [7:0] d;
        rd_reg(2'd0, d);
        idle(2);
        rd_reg(2'd0, d);
        idle(1);
    endtask

    initial begin
        logic [7:0] d;
        tx_space[0] = 7'd64; tx_space[1] = 7'd64;
        rx_count[0] = 7'd0;  rx_count[1] = 7'd0;
        idle(3);
        chk("R5 reset irq", {31'd0, irq}, 0);
        chk("R5 reset summary", {31'd0, irq_summary}, 0);
        chk("R9 reset hold", {30'd0, tx_hold}, 0);
        rst_n = 1'b1;
        idle(1);
        rd_reg(2'd0, d);
        chk("R7 ready after reset", {24'd0, d}, 32'h09);
        rd_reg(2'd1, d);
        chk("R1 mask reset", {24'd0, d}, 0);
        rd_reg(2'd2, d);
        chk("R1 ctrl reset", {24'd0, d}, 0);

        // Sweep: channel x event x mask x visibility.
        for (int c = 0; c < NCH; c++) begin
            for (int e = 0; e < 3; e++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int v = 0; v < 2; v++) begin
                        int bp;
                        logic [7:0] ebit;
                        bp = 3 * c + e;
                        ebit = 8'(1 << bp);
                        wr_reg(2'd1, m ? ebit : 8'h00);
                        wr_reg(2'd2, 8'(v));
                        flush();
                        if (e == 0) begin
                            tx_space[c] = 7'd0; idle(1);
                            tx_space[c] = 7'd64; idle(1);
                        end else if (e == 1) begin
                            rx_count[c] = 7'd32; idle(1);
                        end else begin
                            tx_busy[c] = 1'b1; idle(1);
                            chk("R8 abort pulse", {30'd0, tx_abort}, 32'(1 << c));
                        end
                        chk("R5 irq vs mask", {31'd0, irq}, 32'(m == 0));
                        chk("R5 summary vs mask", {31'd0, irq_summary}, 32'(m == 0));
                        rd_reg(2'd0, d);
                        chk("R4 R11 latch vs mask/vis", {24'd0, d},
                            (m == 0 || v == 1) ? {24'd0, ebit} : 32'd0);
                        if (e == 2) chk("R9 released by read", {30'd0, tx_hold}, 0);
                        rx_count[c] = 7'd0;
                        tx_busy[c] = 1'b0;
                        flush();
                    end
                end
            end
        end
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, 8'h00);
        flush();

        // R3: event coincides with status read.
        rx_count[0] = 7'd32;
        rd_reg(2'd0, d);
        chk("R3 old value on read", {24'd0, d}, 0);
        rd_reg(2'd0, d);
        chk("R3 event kept", {24'd0, d}, 32'h02);

        // R6: level held above threshold fires once.
        rx_count[1] = 7'd40; idle(1);
        rd_reg(2'd0, d);
        chk("R6 first crossing", {24'd0, d}, 32'h10);
        idle(3);
        rd_reg(2'd0, d);
        chk("R6 no refire while high", {24'd0, d}, 0);
        rx_count[0] = 7'd0; rx_count[1] = 7'd0; idle(1);
        rx_count[1] = 7'd35; rx_frame_end[1] = 1'b1; idle(1);
        rx_count[1] = 7'd0; rx_frame_end[1] = 1'b0;
        rd_reg(2'd0, d);
        chk("R6 frame end suppresses", {24'd0, d}, 0);

        // R10: end-of-message pending.
        tx_eom[0] = 1'b1; tx_busy[0] = 1'b1; idle(2);
        chk("R10 no lockout with eom", {30'd0, tx_hold}, 0);
        rd_reg(2'd0, d);
        chk("R10 no underrun bit", {24'd0, d}, 0);
        tx_eom[0] = 1'b0; tx_busy[0] = 1'b0;

        // R9: lockout duration and release.
        tx_busy[1] = 1'b1; idle(1);
        chk("R8 abort ch1", {30'd0, tx_abort}, 32'h2);
        chk("R9 R11 hold ch1 only", {30'd0, tx_hold}, 32'h2);
        tx_busy[1] = 1'b0; idle(1);
        chk("R8 abort one cycle", {30'd0, tx_abort}, 0);
        idle(5);
        chk("R9 still held", {30'd0, tx_hold}, 32'h2);
        rd_reg(2'd1, d);
        chk("R2 mask read keeps hold", {30'd0, tx_hold}, 32'h2);
        chk("R2 mask read keeps irq", {31'd0, irq}, 1);
        rd_reg(2'd0, d);
        chk("R8 underrun bit ch1", {24'd0, d}, 32'h20);
        chk("R9 released", {30'd0, tx_hold}, 0);
        idle(2);
        rd_reg(2'd0, d);
        chk("R7 ready after release", {24'd0, d}, 32'h08);

        // R1: status not writable, ctrl has one bit.
        wr_reg(2'd0, 8'hFF);
        rd_reg(2'd0, d);
        chk("R1 status write ignored", {24'd0, d}, 0);
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd2, d);
        chk("R1 ctrl width", {24'd0, d}, 32'h01);
        wr_reg(2'd1, 8'hA5);
        rd_reg(2'd1, d);
        chk("R1 mask readback", {24'd0, d}, 32'hA5);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule